// File: doc/BRIEF.md
# Optical pulse frame serializer

This block turns a byte stream into a pulse train on one LED output, for a receiver that samples light in fixed frames. Every frame lasts 34 bit periods and holds two byte slots. Each slot opens with a start bit, and its eight data bits follow least significant bit first. A zero bit is a short flash at the start of its bit period. A one bit, a pad bit and every bit of an unused slot are dark.

A session opens as soon as a byte is offered while the block is idle. The block first sends a run of sync frames that carry 0x55 in both slots, then a run of start frames that carry 0xAA in both slots. After these it sends packets. The first byte of a packet gives the total packet length, and that count includes the length byte and the two check bytes already at the tail. Packet bytes fill the frames two at a time. A run of empty frames follows each packet. If no byte is waiting when that run ends, the block goes dark and idle, and the next byte opens a new session with fresh sync frames.

The bit period and the flash width come from the clock frequency. The three frame counts are parameters.

Top module: `led_frame_tx`

## Requirements
- R1: Each bit period is BIT_CYC clock cycles. A zero bit drives `ledOut` high for the first PULSE_CYC cycles of its period and low for the rest. A one bit keeps `ledOut` low for the whole period.
- R2: A frame is 34 consecutive bit periods. Bit 0 is the first slot's start bit and bits 1 to 8 are its byte, bit 0 of the byte first. Bit 12 is the second slot's start bit and bits 13 to 20 are its byte, bit 0 of the byte first. Frames of one session follow each other with no gap.
- R3: Bits 9 to 11 and 21 to 33 are always ones. A start bit is a zero only when its slot holds a byte. An unused slot sends all ones, so an empty frame has no flash at all.
- R4: When a byte is offered in idle, the block sends PRE_FRAMES frames of 0x55,0x55 and then SOT_FRAMES frames of 0xAA,0xAA. No input byte is consumed during these frames.
- R5: The first byte of a packet is its length L, counting itself. The block consumes L bytes and places them in arrival order, first slot then second slot, one frame after another. When only one byte is left at a frame start, that byte goes alone in the first slot.
- R6: Exactly GAP_FRAMES empty frames follow the last byte's frame. If a byte is then offered, the next packet starts in the very next frame. If none is offered, the block goes idle.
- R7: After reset and while idle, `ledOut` is low and `inReady` is low.
- R8: A length byte of 0 or 1 forms a packet of that single byte, which is followed by the gap frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | A byte is offered on inData |
| inReady | output | 1 | The offered byte is taken in this cycle |
| inData | input | 8 | Byte to send |
| ledOut | output | 1 | Registered LED drive, high = lit |

## Verification
The frame counters advance continuously within a session, and `ledOut` is registered one cycle after the counter position. As a result, the flash of bit b in frame k rises exactly k*34*BIT_CYC + b*BIT_CYC cycles after the session's first flash, and lasts PULSE_CYC cycles. The monitor locks onto that first flash. It then samples one cycle into each bit period to see the flash, and samples PULSE_CYC cycles in to see it gone, counting cycles from the lock point instead of watching edges. Each reconstructed 34-bit frame is compared with the next frame that the driver queued from the packet bytes. After a session's last gap frame, the monitor requires two dark frame lengths with no byte taken.

// File: rtl/led_frame_pkg.sv
package led_frame_pkg;
  localparam int FRAME_BITS = 34;
  localparam int SLOT2_START = 12;
  localparam logic [7:0] SYNC_BYTE = 8'h55;
  localparam logic [7:0] OPEN_BYTE = 8'hAA;

  typedef enum logic [2:0] {ST_IDLE, ST_SYNC, ST_OPEN, ST_DATA, ST_GAP} seqState_t;

  typedef struct packed {
    logic       run;
    logic       frameLoad;
    logic       slot1Fill;
    logic [7:0] slot1Byte;
    logic       slot2Load;
    logic       slot2Fill;
    logic [7:0] slot2Byte;
  } frameCmd_t;
endpackage

// File: rtl/led_frame_dp.sv
module led_frame_dp
  import led_frame_pkg::*;
#(
  parameter int BIT_CYC = 98000,
  parameter int PULSE_CYC = 6000
) (
  input  logic      clk,
  input  logic      rst,
  input  frameCmd_t cmd,
  output logic      frameWrap,
  output logic      slot2Fetch,
  output logic      ledOut
);
  localparam int CW = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(BIT_CYC - 1);
  localparam logic [CW-1:0] PULSE_LIM = CW'(PULSE_CYC);
  localparam logic [5:0] LAST_BIT = 6'(FRAME_BITS - 1);
  localparam logic [5:0] PRE_SLOT2 = 6'(SLOT2_START - 1);

  logic [CW-1:0] cnt;
  logic [5:0]    bitIdx;
  logic          s1Full, s2Full;
  logic [7:0]    s1Byte, s2Byte;
  logic          lastCyc, pulseBit;

  assign lastCyc    = (cnt == LAST_CNT);
  assign frameWrap  = lastCyc && (bitIdx == LAST_BIT);
  assign slot2Fetch = lastCyc && (bitIdx == PRE_SLOT2);

  always_comb begin
    pulseBit = 1'b0;
    if (bitIdx == 6'd0)
      pulseBit = s1Full;
    else if (bitIdx <= 6'd8)
      pulseBit = s1Full && !s1Byte[3'(bitIdx - 6'd1)];
    else if (bitIdx == 6'(SLOT2_START))
      pulseBit = s2Full;
    else if (bitIdx > 6'(SLOT2_START) && bitIdx <= 6'(SLOT2_START + 8))
      pulseBit = s2Full && !s2Byte[3'(bitIdx - 6'(SLOT2_START + 1))];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= LAST_CNT;
      bitIdx <= LAST_BIT;
      s1Full <= 1'b0;
      s2Full <= 1'b0;
      s1Byte <= '0;
      s2Byte <= '0;
      ledOut <= 1'b0;
    end else begin
      if (!cmd.run) begin
        cnt    <= LAST_CNT;
        bitIdx <= LAST_BIT;
      end else if (lastCyc) begin
        cnt    <= '0;
        bitIdx <= (bitIdx == LAST_BIT) ? 6'd0 : bitIdx + 6'd1;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (cmd.frameLoad) begin
        s1Full <= cmd.slot1Fill;
        s1Byte <= cmd.slot1Byte;
        s2Full <= cmd.slot2Fill;
        s2Byte <= cmd.slot2Byte;
      end else if (cmd.slot2Load) begin
        s2Full <= cmd.slot2Fill;
        s2Byte <= cmd.slot2Byte;
      end
      ledOut <= pulseBit && (cnt < PULSE_LIM);
    end
  end

  // R1: a flash always begins at the start of a bit period
  assert_flash_start_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(ledOut) |-> (cnt == CW'(1)));

  // R3: no flash ever comes from a pad position
  assert_pad_dark_R3: assert property (@(posedge clk) disable iff (rst)
    ledOut |-> !(($past(bitIdx) >= 6'd9 && $past(bitIdx) <= 6'd11) || $past(bitIdx) >= 6'd21));
endmodule

// File: rtl/led_frame_ctrl.sv
module led_frame_ctrl
  import led_frame_pkg::*;
#(
  parameter int SYNC_FRAMES = 50,
  parameter int OPEN_FRAMES = 25,
  parameter int GAP_FRAMES = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frameWrap,
  input  logic       slot2Fetch,
  input  logic       inValid,
  input  logic [7:0] inData,
  output logic       inReady,
  output frameCmd_t  cmd
);
  localparam int MAXA = (SYNC_FRAMES > OPEN_FRAMES) ? SYNC_FRAMES : OPEN_FRAMES;
  localparam int MAXF = (MAXA > GAP_FRAMES) ? MAXA : GAP_FRAMES;
  localparam int FW = $clog2(MAXF + 1) + 1;

  seqState_t      state, stateN;
  logic [FW-1:0]  frames;
  logic [7:0]     remaining;
  logic           pktStart, newPkt, take, lenTake;

  always_comb begin
    stateN  = state;
    cmd     = '0;
    take    = 1'b0;
    newPkt  = 1'b0;
    if (frameWrap) begin
      cmd.frameLoad = 1'b1;
      unique case (state)
        ST_IDLE: if (inValid) stateN = ST_SYNC;
        ST_SYNC: if (frames == FW'(SYNC_FRAMES)) stateN = ST_OPEN;
        ST_OPEN: if (frames == FW'(OPEN_FRAMES)) stateN = ST_DATA;
        ST_DATA: if (!pktStart && remaining == 8'd0) stateN = ST_GAP;
        ST_GAP:  if (frames == FW'(GAP_FRAMES)) stateN = inValid ? ST_DATA : ST_IDLE;
        default: stateN = ST_IDLE;
      endcase
      newPkt = (stateN == ST_DATA) && (state != ST_DATA);
      if (stateN == ST_SYNC || stateN == ST_OPEN) begin
        cmd.slot1Fill = 1'b1;
        cmd.slot2Fill = 1'b1;
        cmd.slot1Byte = (stateN == ST_SYNC) ? SYNC_BYTE : OPEN_BYTE;
        cmd.slot2Byte = cmd.slot1Byte;
      end else if (stateN == ST_DATA) begin
        take          = inValid;
        cmd.slot1Fill = inValid;
        cmd.slot1Byte = inData;
      end
    end else if (slot2Fetch && state == ST_DATA && !pktStart && remaining != 8'd0) begin
      cmd.slot2Load = 1'b1;
      cmd.slot2Fill = inValid;
      cmd.slot2Byte = inData;
      take          = inValid;
    end
    cmd.run = (stateN != ST_IDLE);
  end

  assign inReady = take;
  assign lenTake = take && frameWrap && (pktStart || newPkt);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      frames    <= '0;
      remaining <= '0;
      pktStart  <= 1'b0;
    end else begin
      state <= stateN;
      if (frameWrap)
        frames <= (stateN != state) ? FW'(1) : frames + 1'b1;
      if (lenTake) begin
        remaining <= (inData > 8'd1) ? inData - 8'd1 : 8'd0;
        pktStart  <= 1'b0;
      end else if (take) begin
        remaining <= remaining - 8'd1;
      end else if (newPkt) begin
        pktStart <= 1'b1;
      end
    end
  end

  // R4: sync and start frames never consume input
  assert_no_take_sync_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SYNC || state == ST_OPEN) && !frameWrap |-> !inReady);

  // R5: every consumed byte lands in a data frame
  assert_take_in_data_R5: assert property (@(posedge clk) disable iff (rst)
    inReady |=> (state == ST_DATA));

  // R6: gap frame count stays inside its window
  assert_gap_window_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_GAP) |-> (frames >= FW'(1) && frames <= FW'(GAP_FRAMES)));

  // R8: a length byte is consumed only once per packet
  assert_len_once_R8: assert property (@(posedge clk) disable iff (rst)
    lenTake |=> !pktStart);
endmodule

// File: rtl/led_frame_tx.sv
module led_frame_tx
  import led_frame_pkg::*;
#(
  parameter int CLK_HZ = 200000000,
  parameter int BIT_US = 490,
  parameter int PULSE_US = 30,
  parameter int SYNC_FRAMES = 50,
  parameter int OPEN_FRAMES = 25,
  parameter int GAP_FRAMES = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output logic       inReady,
  input  logic [7:0] inData,
  output logic       ledOut
);
  localparam longint BIT_L = (longint'(CLK_HZ) * longint'(BIT_US)) / 64'd1000000;
  localparam longint PULSE_L = (longint'(CLK_HZ) * longint'(PULSE_US)) / 64'd1000000;
  localparam int BIT_CYC = int'(BIT_L);
  localparam int PULSE_CYC = (PULSE_L < 1) ? 1 : int'(PULSE_L);

  frameCmd_t cmd;
  logic      frameWrap, slot2Fetch;

  led_frame_ctrl #(.SYNC_FRAMES(SYNC_FRAMES), .OPEN_FRAMES(OPEN_FRAMES), .GAP_FRAMES(GAP_FRAMES)) uCtrl (
    .clk(clk), .rst(rst), .frameWrap(frameWrap), .slot2Fetch(slot2Fetch),
    .inValid(inValid), .inData(inData), .inReady(inReady), .cmd(cmd));

  led_frame_dp #(.BIT_CYC(BIT_CYC), .PULSE_CYC(PULSE_CYC)) uDp (
    .clk(clk), .rst(rst), .cmd(cmd), .frameWrap(frameWrap),
    .slot2Fetch(slot2Fetch), .ledOut(ledOut));

  // R7: the LED stays dark while the sequencer is idle
  assert_idle_dark_R7: assert property (@(posedge clk) disable iff (rst)
    (!cmd.run && !$past(cmd.run)) |-> !ledOut);
endmodule

// File: tb/sim_led_frame_tx.sv
`timescale 1ns/1ps
module sim_led_frame_tx;
  localparam int CLK_HZ = 100000;
  localparam int B = 49;
  localparam int P = 3;
  localparam int F = 34 * B;
  localparam int NSYNC = 2, NOPEN = 2, NGAP = 2;

  logic clk = 1'b0, rst = 1'b1, inValid, inReady, ledOut;
  logic [7:0] inData;
  int checks = 0, errors = 0, sessionsDone = 0;
  bit finished = 1'b0;

  logic [7:0]  stimQ[$];
  logic [7:0]  pktBuf[$];
  logic [33:0] expMask[$];
  bit          expLast[$];
  string       expTag[$];

  always #2.5 clk = ~clk;

  led_frame_tx #(.CLK_HZ(CLK_HZ), .BIT_US(490), .PULSE_US(30), .SYNC_FRAMES(NSYNC),
    .OPEN_FRAMES(NOPEN), .GAP_FRAMES(NGAP)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData), .ledOut(ledOut));

  function automatic logic [33:0] mkMask(bit f1, logic [7:0] d1, bit f2, logic [7:0] d2);
    logic [33:0] m = '0;
    m[0]  = f1;
    m[12] = f2;
    for (int i = 0; i < 8; i++) begin
      m[1 + i]  = f1 && !d1[i];
      m[13 + i] = f2 && !d2[i];
    end
    return m;
  endfunction

  task automatic pushFrame(logic [33:0] m, string tag);
    expMask.push_back(m); expLast.push_back(1'b0); expTag.push_back(tag);
  endtask

  task automatic startSession();
    for (int i = 0; i < NSYNC; i++) pushFrame(mkMask(1, 8'h55, 1, 8'h55), "R1 R2 R4 sync");
    for (int i = 0; i < NOPEN; i++) pushFrame(mkMask(1, 8'hAA, 1, 8'hAA), "R2 R4 start");
  endtask

  task automatic pushByte(logic [7:0] b);
    stimQ.push_back(b); pktBuf.push_back(b);
  endtask

  task automatic endPkt(string tag);
    int n = pktBuf.size();
    for (int i = 0; i < n; i += 2) begin
      if (i + 1 < n) pushFrame(mkMask(1, pktBuf[i], 1, pktBuf[i+1]), tag);
      else           pushFrame(mkMask(1, pktBuf[i], 0, 8'h00), tag);
    end
    for (int i = 0; i < NGAP; i++) pushFrame('0, "R3 R6 gap");
    pktBuf.delete();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // driver: present queue head, pop on handshake
  initial begin
    inValid = 1'b0; inData = 8'h00;
    forever begin
      @(posedge clk);
      if (inValid && inReady) void'(stimQ.pop_front());
      #1;
      inValid = (stimQ.size() > 0);
      inData  = inValid ? stimQ[0] : 8'h00;
    end
  end

  // monitor: lock on first flash of a session, then decode frames by cycle count
  initial begin
    forever begin
      logic [33:0] got;
      bit wideBad, last, idleBad;
      do @(negedge clk); while (!(ledOut === 1'b1 && !rst));
      last = 1'b0;
      while (!last) begin
        got = '0; wideBad = 1'b0;
        for (int b = 0; b < 34; b++) begin
          @(negedge clk);
          got[b] = ledOut;
          repeat (P - 1) @(negedge clk);
          if (ledOut !== 1'b0) wideBad = 1'b1;
          repeat (B - P) @(negedge clk);
        end
        checks++;
        if (expMask.size() == 0) begin
          errors++;
          $display("FAIL R2 unexpected frame got %h expected none", got);
          last = 1'b1;
        end else begin
          if (got !== expMask[0] || wideBad) begin
            errors++;
            $display("FAIL %s R1 got %h wide=%0d expected %h wide=0", expTag[0], got, wideBad, expMask[0]);
          end
          last = expLast[0];
          void'(expMask.pop_front()); void'(expLast.pop_front()); void'(expTag.pop_front());
        end
      end
      idleBad = 1'b0;
      for (int c = 0; c < 2 * F; c++) begin
        if (ledOut !== 1'b0 || inReady !== 1'b0) idleBad = 1'b1;
        @(negedge clk);
      end
      checks++;
      if (idleBad) begin
        errors++;
        $display("FAIL R6 R7 idle after session: activity=1 expected 0");
      end
      sessionsDone++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got running expected done");
    finish();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (ledOut !== 1'b0 || inReady !== 1'b0) begin
      errors++;
      $display("FAIL R7 reset led=%0b ready=%0b expected 0 0", ledOut, inReady);
    end
    // session 1: odd then even packet, back to back (R5, R6)
    startSession();
    pushByte(8'h05); pushByte(8'h11); pushByte(8'h22); pushByte(8'h33); pushByte(8'h44);
    endPkt("R2 R5 odd packet");
    pushByte(8'h04); pushByte(8'hA1); pushByte(8'hB2); pushByte(8'hC3);
    endPkt("R2 R5 even packet");
    expLast[$] = 1'b1;
    wait (sessionsDone == 1);
    // session 2: fresh sync after idle, lengths 1 and 0, then a 3-byte packet (R8)
    startSession();
    pushByte(8'h01);
    endPkt("R8 length one");
    pushByte(8'h00);
    endPkt("R8 length zero");
    pushByte(8'h03); pushByte(8'h5A); pushByte(8'h0F);
    endPkt("R5 three byte packet");
    expLast[$] = 1'b1;
    wait (sessionsDone == 2);
    checks++;
    if (stimQ.size() != 0 || expMask.size() != 0) begin
      errors++;
      $display("FAIL R5 leftover bytes=%0d frames=%0d expected 0 0", stimQ.size(), expMask.size());
    end
    finish();
  end
endmodule